// File: doc/BRIEF.md
# LED Status Driver with Event Stretching

This block drives two indicator LED pins from a network port's status signals: link up, full duplex, transmit activity, receive activity and collision. A 16-bit control word gives each pin its own 4-bit mode. Depending on the mode, a pin shows one status as a plain level or shows an activity event. It can also be forced on or off, or blink at one of two rates. An activity event lasts only a few clock cycles on the wire. A shared stretch-length code and a stretch-enable bit hold such events on long enough for a person to see them. Some combined modes are stretched whether or not the enable bit is set.

An LED may be wired so that the pin sources current to light it, or so that the pin sinks current. While reset is held, the block samples the level of each pin and keeps that polarity until the next reset. The sample taken on the second pin also gives the port's default duplex setting. Stretch times are parameters counted in clock cycles. At a 25 MHz clock they are 40 ms, 70 ms and 140 ms. The blink rates are parameters given as powers of two. All outputs are registered, so an output follows its inputs one clock edge later. The suggested power-up control word is 0x3326: pin 0 shows collisions, pin 1 shows receive activity, the medium length is selected and stretching is on.

Top module: `led_status_drv`

## Requirements
- R1: While `rst` is high, each `led_out` bit equals its `pin_sense` bit, which is the unlit level. After reset, with no status active and any status-driven mode, each output stays at its unlit level.
- R2: Codes 0001 (transmit), 0010 (receive), 0011 (collision) and 0111 (transmit or receive) are stretchable event modes. When stretch enable is 0, the pin is lit exactly while its event is present, one edge later.
- R3: Code 1000 lights the pin steadily. Codes 1001, 0000, 0110 and 1111 keep it dark, whatever the status inputs do.
- R4: Code 0100 lights the pin while `link_up` is high. Code 0101 lights it while `full_duplex` is high.
- R5: When stretch enable is 1, an event that lasts one cycle keeps a stretchable-mode pin lit for LEN+1 consecutive cycles. LEN is STRETCH_SHORT for length code 00, STRETCH_MED for 01, and STRETCH_LONG for 10 and for the reserved code 11.
- R6: An event that arrives while a stretch is still running restarts the full stretch time from that event.
- R7: Code 1100 (link with receive activity) and code 1101 (link with any activity) light the pin while the link is up. A matching event turns the pin dark for LEN+1 cycles, and this happens whether stretch enable is set or not. With the link down the pin stays dark.
- R8: Code 1110 shows the duplex level. A collision inverts it for the stretch time, whatever stretch enable is set to.
- R9: Code 1010 toggles the pin every 2^FAST_LOG2 cycles and code 1011 every 2^SLOW_LOG2 cycles.
- R10: A `pin_sense` bit of 1 sampled during reset means the LED sinks current, so the pin is driven low when lit. A bit of 0 means it is driven high when lit. Changes on `pin_sense` after reset have no effect until the next reset.
- R11: `duplex_default` equals the `pin_sense[1]` value sampled during reset: 1 is full duplex, 0 is half duplex. It holds after reset.
- R12: Control word fields: [11:8] is the pin 0 mode, [7:4] the pin 1 mode, [3:2] the stretch length code and [1] stretch enable. Bits [15:12] and [0] are ignored. The two pins act independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; polarity is sampled while it is high |
| link_up | input | 1 | Link status |
| full_duplex | input | 1 | Duplex status, 1 = full |
| tx_act | input | 1 | Transmit activity event |
| rx_act | input | 1 | Receive activity event |
| collision | input | 1 | Collision event |
| pin_sense | input | 2 | Sensed LED wiring per pin, 1 = sinking |
| ctrl | input | 16 | Control word (modes, stretch length, stretch enable) |
| led_out | output | 2 | LED pin drive levels |
| duplex_default | output | 1 | Default duplex bit taken from pin 1 wiring |

## Verification
The case most likely to hide a fault is a new activity event that lands while the stretch counter is still counting down from an earlier one. In that cycle the reload and the decrement compete for the same counter. The bench fires a second one-cycle pulse four cycles into a medium stretch. It then counts the lit cycles that follow the second pulse and expects the full LEN+1 rather than the shorter remainder of the first stretch. The same collision is tested in the inverted link-with-activity mode, where a burst of events must keep the pin dark and not flicker it.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;

  typedef enum logic [3:0] {
    MODE_RSV0      = 4'b0000,
    MODE_TX        = 4'b0001,
    MODE_RX        = 4'b0010,
    MODE_COL       = 4'b0011,
    MODE_LINK      = 4'b0100,
    MODE_DPX       = 4'b0101,
    MODE_RSV6      = 4'b0110,
    MODE_TXRX      = 4'b0111,
    MODE_ON        = 4'b1000,
    MODE_OFF       = 4'b1001,
    MODE_FAST      = 4'b1010,
    MODE_SLOW      = 4'b1011,
    MODE_LINK_RX   = 4'b1100,
    MODE_LINK_TXRX = 4'b1101,
    MODE_DPX_COL   = 4'b1110,
    MODE_RSV15     = 4'b1111
  } led_mode_e;

  typedef struct packed {
    logic link;
    logic duplex;
    logic tx;
    logic rx;
    logic col;
  } net_status_t;

  // Suggested power-up control word: pin0 collision, pin1 receive, medium length, stretch on
  localparam logic [15:0] CTRL_POWERUP = 16'h3326;

  // Event that feeds a pin's stretch timer for a given mode
  function automatic logic mode_event(led_mode_e m, net_status_t s);
    case (m)
      MODE_TX:                   return s.tx;
      MODE_RX, MODE_LINK_RX:     return s.rx;
      MODE_COL, MODE_DPX_COL:    return s.col;
      MODE_TXRX, MODE_LINK_TXRX: return s.tx | s.rx;
      default:                   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
  parameter int unsigned FAST_LOG2 = 21,
  parameter int unsigned SLOW_LOG2 = 23
) (
  input  logic clk,
  input  logic rst,
  output logic blink_fast,
  output logic blink_slow
);
  localparam int unsigned CW = SLOW_LOG2 + 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + CW'(1);
  end

  assign blink_fast = cnt[FAST_LOG2];
  assign blink_slow = cnt[SLOW_LOG2];

  // R9: each phase flips right after its lower counter bits wrap
  assert_fast_toggle_R9: assert property (@(posedge clk) disable iff (rst)
    (&cnt[FAST_LOG2-1:0]) |=> (blink_fast != $past(blink_fast)));
  assert_slow_toggle_R9: assert property (@(posedge clk) disable iff (rst)
    (&cnt[SLOW_LOG2-1:0]) |=> (blink_slow != $past(blink_slow)));

endmodule

// File: rtl/led_stretch.sv
module led_stretch #(
  parameter int unsigned STRETCH_SHORT = 1000000,
  parameter int unsigned STRETCH_MED   = 1750000,
  parameter int unsigned STRETCH_LONG  = 3500000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       evt,
  input  logic [1:0] len_sel,
  output logic       active
);
  localparam int unsigned TW = $clog2(STRETCH_LONG + 1);

  logic [TW-1:0] timer;
  logic [TW-1:0] len_val;

  always_comb begin
    case (len_sel)
      2'b00:   len_val = TW'(STRETCH_SHORT);
      2'b01:   len_val = TW'(STRETCH_MED);
      default: len_val = TW'(STRETCH_LONG);
    endcase
  end

  // Every event reloads the full length, so a burst keeps the stretch alive
  always_ff @(posedge clk) begin
    if (rst)                timer <= '0;
    else if (evt)           timer <= len_val;
    else if (timer != '0)   timer <= timer - TW'(1);
  end

  assign active = evt | (timer != '0);

  // R5: the cycle after an event ends is still covered by the stretch
  assert_hold_after_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(evt)) |-> active);
  // R6: reloads never push the timer past the longest length
  assert_timer_bound_R6: assert property (@(posedge clk) disable iff (rst)
    timer <= TW'(STRETCH_LONG));

endmodule

// File: rtl/led_pin.sv
module led_pin
  import led_drv_pkg::*;
#(
  parameter int unsigned STRETCH_SHORT = 1000000,
  parameter int unsigned STRETCH_MED   = 1750000,
  parameter int unsigned STRETCH_LONG  = 3500000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  mode,
  input  net_status_t st,
  input  logic        stretch_en,
  input  logic [1:0]  len_sel,
  input  logic        blink_fast,
  input  logic        blink_slow,
  input  logic        pol,
  input  logic        rst_level,
  output logic        led_drv
);
  led_mode_e m;
  logic      evt;
  logic      str_act;
  logic      lit;

  assign m   = led_mode_e'(mode);
  assign evt = mode_event(m, st);

  led_stretch #(
    .STRETCH_SHORT(STRETCH_SHORT),
    .STRETCH_MED  (STRETCH_MED),
    .STRETCH_LONG (STRETCH_LONG)
  ) u_stretch (
    .clk    (clk),
    .rst    (rst),
    .evt    (evt),
    .len_sel(len_sel),
    .active (str_act)
  );

  always_comb begin
    case (m)
      MODE_TX, MODE_RX, MODE_COL, MODE_TXRX: lit = stretch_en ? str_act : evt;
      MODE_LINK:                             lit = st.link;
      MODE_DPX:                              lit = st.duplex;
      MODE_ON:                               lit = 1'b1;
      MODE_FAST:                             lit = blink_fast;
      MODE_SLOW:                             lit = blink_slow;
      MODE_LINK_RX, MODE_LINK_TXRX:          lit = st.link & ~str_act;
      MODE_DPX_COL:                          lit = st.duplex ^ str_act;
      default:                               lit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) led_drv <= rst_level;
    else     led_drv <= lit ^ pol;
  end

  // R3: forced-on mode drives the lit level on the next edge
  assert_force_on_R3: assert property (@(posedge clk) disable iff (rst)
    (m == MODE_ON) |=> (led_drv == ~pol));
  // R3: off and reserved codes drive the dark level on the next edge
  assert_force_off_R3: assert property (@(posedge clk) disable iff (rst)
    (m == MODE_OFF || m == MODE_RSV0 || m == MODE_RSV6 || m == MODE_RSV15)
    |=> (led_drv == pol));

endmodule

// File: rtl/led_status_drv.sv
module led_status_drv
  import led_drv_pkg::*;
#(
  parameter int unsigned STRETCH_SHORT = 1000000,
  parameter int unsigned STRETCH_MED   = 1750000,
  parameter int unsigned STRETCH_LONG  = 3500000,
  parameter int unsigned FAST_LOG2     = 21,
  parameter int unsigned SLOW_LOG2     = 23,
  parameter int unsigned NUM_PINS      = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                link_up,
  input  logic                full_duplex,
  input  logic                tx_act,
  input  logic                rx_act,
  input  logic                collision,
  input  logic [NUM_PINS-1:0] pin_sense,
  input  logic [15:0]         ctrl,
  output logic [NUM_PINS-1:0] led_out,
  output logic                duplex_default
);
  localparam int unsigned MODE_W = 4;

  net_status_t         st;
  logic [NUM_PINS-1:0] pol_q;
  logic                blink_fast;
  logic                blink_slow;
  logic [1:0]          len_sel;
  logic                stretch_en;
  logic                unused_ctrl;

  assign st          = '{link: link_up, duplex: full_duplex, tx: tx_act,
                         rx: rx_act, col: collision};
  assign len_sel     = ctrl[3:2];
  assign stretch_en  = ctrl[1];
  assign unused_ctrl = ^{ctrl[15:12], ctrl[0]};

  // Wiring is sampled only while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q          <= pin_sense;
      duplex_default <= pin_sense[NUM_PINS-1];
    end
  end

  led_blink_gen #(
    .FAST_LOG2(FAST_LOG2),
    .SLOW_LOG2(SLOW_LOG2)
  ) u_blink (
    .clk       (clk),
    .rst       (rst),
    .blink_fast(blink_fast),
    .blink_slow(blink_slow)
  );

  // Pin 0 takes the highest mode nibble, later pins the next lower ones
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int unsigned LSB = 4 + MODE_W * (NUM_PINS - 1 - p);
    led_pin #(
      .STRETCH_SHORT(STRETCH_SHORT),
      .STRETCH_MED  (STRETCH_MED),
      .STRETCH_LONG (STRETCH_LONG)
    ) u_pin (
      .clk       (clk),
      .rst       (rst),
      .mode      (ctrl[LSB +: MODE_W]),
      .st        (st),
      .stretch_en(stretch_en),
      .len_sel   (len_sel),
      .blink_fast(blink_fast),
      .blink_slow(blink_slow),
      .pol       (pol_q[p]),
      .rst_level (pin_sense[p]),
      .led_drv   (led_out[p])
    );
  end

  // R10: the sampled polarity holds once reset is released
  assert_pol_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(pol_q));
  // R11: the duplex default agrees with the latched second-pin wiring
  assert_dup_default_R11: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (duplex_default == pol_q[NUM_PINS-1]) && $stable(duplex_default));

endmodule

// File: tb/led_status_drv_bench.sv
module led_status_drv_bench;
  localparam int SH = 6;
  localparam int MD = 10;
  localparam int LG = 20;
  localparam time HALF = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        link_up = 0, full_duplex = 0, tx_act = 0, rx_act = 0, collision = 0;
  logic [1:0]  pin_sense = 2'b00;
  logic [15:0] ctrl = 16'h3326;
  logic [1:0]  led_out;
  logic        duplex_default;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #HALF clk = ~clk;

  led_status_drv #(
    .STRETCH_SHORT(SH), .STRETCH_MED(MD), .STRETCH_LONG(LG),
    .FAST_LOG2(3), .SLOW_LOG2(5), .NUM_PINS(2)
  ) u_led_status_drv (
    .clk(clk), .rst(rst), .link_up(link_up), .full_duplex(full_duplex),
    .tx_act(tx_act), .rx_act(rx_act), .collision(collision),
    .pin_sense(pin_sense), .ctrl(ctrl), .led_out(led_out),
    .duplex_default(duplex_default)
  );

  function automatic logic [15:0] mk(input logic [3:0] a, input logic [3:0] b,
                                     input logic [1:0] len, input logic en);
    return {4'b1010, a, b, len, en, 1'b1};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_status();
    link_up = 0; full_duplex = 0; tx_act = 0; rx_act = 0; collision = 0;
  endtask

  // Count consecutive samples on which a pin sits at the given level
  task automatic count_level(input int pin, input logic lvl, output int n);
    n = 0;
    while (led_out[pin] == lvl && n < 400) begin
      n++;
      step();
    end
  endtask

  task automatic do_reset(input logic [1:0] sense);
    rst = 1; pin_sense = sense;
    repeat (3) step();
    chk("R1 reset level", led_out, sense);
    rst = 0;
    step();
  endtask

  task automatic t_reset();
    clear_status();
    ctrl = 16'h3326;
    do_reset(2'b00);
    step();
    chk("R1 idle after reset", led_out, 0);
    chk("R11 duplex default half", duplex_default, 0);
  endtask

  task automatic t_direct();
    clear_status();
    ctrl = mk(4'b0001, 4'b0010, 2'b00, 1'b0);
    repeat (LG + 2) step();
    tx_act = 1; step();
    chk("R2 tx mode pin0 / rx pin1 dark (R12)", led_out, 2'b01);
    tx_act = 0; rx_act = 1; step();
    chk("R2 rx mode pin1", led_out, 2'b10);
    rx_act = 0; step();
    chk("R2 no stretch when disabled", led_out, 2'b00);
    ctrl = mk(4'b0011, 4'b0111, 2'b00, 1'b0);
    collision = 1; step();
    chk("R2 collision mode pin0", led_out, 2'b01);
    collision = 0; rx_act = 1; step();
    chk("R2 tx-or-rx mode pin1", led_out, 2'b10);
    rx_act = 0; tx_act = 1; step();
    chk("R2 tx-or-rx mode pin1 via tx", led_out, 2'b10);
    tx_act = 0; step();
    // ignored bits [15:12] and [0]
    ctrl = {4'b0101, 4'b1000, 4'b1001, 2'b00, 1'b0, 1'b0}; step();
    chk("R12 ignored bits flipped", led_out, 2'b01);
    ctrl = {4'b1010, 4'b1000, 4'b1001, 2'b00, 1'b0, 1'b1}; step();
    chk("R12 ignored bits flipped back", led_out, 2'b01);
  endtask

  task automatic t_fixed();
    link_up = 1; full_duplex = 1; tx_act = 1; rx_act = 1; collision = 1;
    ctrl = mk(4'b1000, 4'b1001, 2'b00, 1'b1); step();
    chk("R3 on / off", led_out, 2'b01);
    ctrl = mk(4'b0000, 4'b0110, 2'b00, 1'b1); step();
    chk("R3 reserved 0000 and 0110 dark", led_out, 2'b00);
    ctrl = mk(4'b1111, 4'b1000, 2'b00, 1'b1); step();
    chk("R3 reserved 1111 dark", led_out, 2'b10);
    clear_status();
  endtask

  task automatic t_level();
    clear_status();
    ctrl = mk(4'b0100, 4'b0101, 2'b00, 1'b1);
    link_up = 1; step();
    chk("R4 link level", led_out, 2'b01);
    link_up = 0; full_duplex = 1; step();
    chk("R4 duplex level", led_out, 2'b10);
    full_duplex = 0; step();
    chk("R4 both low", led_out, 2'b00);
  endtask

  task automatic pulse_count(input logic [1:0] len, input logic en, output int n);
    clear_status();
    ctrl = mk(4'b0001, 4'b1001, len, en);
    repeat (LG + 2) step();
    tx_act = 1; step();
    tx_act = 0;
    count_level(0, 1'b1, n);
  endtask

  task automatic t_stretch();
    int n;
    pulse_count(2'b00, 1'b1, n); chk("R5 short length", n, SH + 1);
    pulse_count(2'b01, 1'b1, n); chk("R5 medium length", n, MD + 1);
    pulse_count(2'b10, 1'b1, n); chk("R5 long length", n, LG + 1);
    pulse_count(2'b11, 1'b1, n); chk("R5 reserved code uses long", n, LG + 1);
    pulse_count(2'b10, 1'b0, n); chk("R2 disabled shows one cycle", n, 1);
  endtask

  task automatic t_retrig();
    int n;
    clear_status();
    ctrl = mk(4'b0010, 4'b1001, 2'b01, 1'b1);
    repeat (LG + 2) step();
    rx_act = 1; step();
    rx_act = 0; step(); step(); step();
    rx_act = 1; step();
    rx_act = 0;
    count_level(0, 1'b1, n);
    chk("R6 retrigger restarts full stretch", n, MD + 1);
  endtask

  task automatic t_link_act();
    int n;
    clear_status();
    link_up = 1;
    ctrl = mk(4'b1101, 4'b1100, 2'b00, 1'b0);
    repeat (LG + 2) step();
    chk("R7 link shown on both", led_out, 2'b11);
    tx_act = 1; step();
    tx_act = 0;
    chk("R7 tx darkens 1101 only", led_out, 2'b10);
    count_level(0, 1'b0, n);
    chk("R7 dark for stretch with enable clear", n, SH + 1);
    // burst of rx events keeps pin1 dark throughout
    repeat (LG + 2) step();
    for (int i = 0; i < 3; i++) begin
      rx_act = 1; step(); rx_act = 0; step();
    end
    count_level(1, 1'b0, n);
    chk("R7 burst keeps pin dark then full stretch", n, SH);
    link_up = 0; repeat (2) step();
    chk("R7 link down dark", led_out, 2'b00);
  endtask

  task automatic t_dpx_col();
    int n;
    clear_status();
    ctrl = mk(4'b1110, 4'b1001, 2'b00, 1'b0);
    full_duplex = 1;
    repeat (LG + 2) step();
    chk("R8 duplex shown", led_out[0], 1);
    collision = 1; step(); collision = 0;
    count_level(0, 1'b0, n);
    chk("R8 collision inverts full duplex", n, SH + 1);
    full_duplex = 0; step();
    collision = 1; step(); collision = 0;
    count_level(0, 1'b1, n);
    chk("R8 collision inverts half duplex", n, SH + 1);
  endtask

  task automatic t_blink();
    int tf, ts;
    logic [1:0] prev;
    clear_status();
    ctrl = mk(4'b1010, 4'b1011, 2'b00, 1'b1);
    step(); step();
    tf = 0; ts = 0;
    prev = led_out;
    for (int i = 0; i < 64; i++) begin
      step();
      if (led_out[0] != prev[0]) tf++;
      if (led_out[1] != prev[1]) ts++;
      prev = led_out;
    end
    chk("R9 fast blink toggles", tf, 8);
    chk("R9 slow blink toggles", ts, 2);
  endtask

  task automatic t_polarity();
    clear_status();
    ctrl = mk(4'b1000, 4'b1000, 2'b00, 1'b1);
    do_reset(2'b10);
    step();
    chk("R10 sourcing pin0 on=high, sinking pin1 on=low", led_out, 2'b01);
    chk("R11 duplex default full", duplex_default, 1);
    pin_sense = 2'b01; step(); step();
    chk("R10 sense change ignored", led_out, 2'b01);
    chk("R11 duplex default held", duplex_default, 1);
    ctrl = mk(4'b1001, 4'b1001, 2'b00, 1'b1); step();
    chk("R10 dark levels", led_out, 2'b10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_direct();
    t_fixed();
    t_level();
    t_stretch();
    t_retrig();
    t_link_act();
    t_dpx_col();
    t_blink();
    t_polarity();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule